// File: doc/BRIEF.md
# Interrupt-Started DMA Engine with Summing Transfer

This block moves data on behalf of a peripheral interrupt so that no CPU service routine has to run. A request arrives on an interrupt line with a 3-bit priority level. The engine starts only for the highest level, and only while routing to DMA is enabled and the fast-interrupt path is not selected. Once started, it runs one of four transfer kinds over a simple synchronous memory master port. It can copy memory to memory, write an immediate value, or write a sum to the destination. The sum adds the destination's current contents to either a source memory element or the immediate value.

Software writes a descriptor through a load interface. The descriptor holds the element size, the address update of each side, single or burst operation, a link flag and a count. A second descriptor slot holds the set that replaces the active one when a linked transfer count runs out. An end-of-transfer pulse marks every expiry of the count. A busy output covers the span from acceptance to the final acknowledged write.

Top module: `irqdma_top`

## Requirements
- R1: A request starts work only when `irq_req` is high, `irq_level` equals 3'b111, `dma_route_en` is 1 and `fast_irq_sel` is 0; any other request is dropped and causes no memory access.
- R2: Kind 2'b00 (copy) reads one element at the source address and writes it to the destination address.
- R3: Kind 2'b01 (immediate) writes the descriptor immediate, cut to the element size, to the destination without any read.
- R4: Kind 2'b10 writes (source element + destination element) and kind 2'b11 writes (immediate + destination element) to the destination, cut to the element size with the carry dropped.
- R5: With `desc_word` 0 each access is one byte (`mem_word` 0, data on bits 7:0, upper write bits zero); with `desc_word` 1 each access is a 16-bit word stored low byte first.
- R6: Each of the source and destination addresses either stays fixed or advances after every element, by 1 for bytes and 2 for words, selected independently.
- R7: Addresses are 17 bits; a word access at 0xFFFF is presented as 0xFFFF, and the next forward address is 0x10001, with no wrap to zero.
- R8: In single mode (`desc_burst` 0) each accepted request moves one element; in burst mode one request moves elements until the count reaches zero.
- R9: When the count reaches zero, `eot_irq` pulses high for exactly one cycle after the final write's ready; a request accepted with a count of zero moves nothing.
- R10: If the link flag is set when the count reaches zero, the second descriptor slot (count, addresses, immediate, mode) becomes the active set.
- R11: A qualifying request that arrives while busy is held and served right after the current work ends; any further such requests during the same busy span are merged into that one.
- R12: `busy` rises in the cycle after a request is accepted and falls in the cycle after the last write of that request is acknowledged.
- R13: Writes to the active descriptor slot while busy are ignored.
- R14: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Peripheral interrupt request |
| irq_level | input | 3 | Priority level of the request |
| dma_route_en | input | 1 | Sends top-level requests to the engine |
| fast_irq_sel | input | 1 | Fast-interrupt path selected (blocks the engine) |
| desc_we | input | 1 | Descriptor write strobe |
| desc_link_sel | input | 1 | 0 writes the active slot, 1 writes the link slot |
| desc_kind | input | 2 | Transfer kind (see R2 to R4) |
| desc_word | input | 1 | Element size: 0 byte, 1 word |
| desc_src_inc | input | 1 | Source address advances |
| desc_dst_inc | input | 1 | Destination address advances |
| desc_burst | input | 1 | Burst mode |
| desc_link | input | 1 | Load the link slot at count zero |
| desc_count | input | 16 | Element count |
| desc_src | input | 16 | Source address |
| desc_dst | input | 16 | Destination address |
| desc_imm | input | 16 | Immediate operand |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | Access size: 0 byte, 1 word |
| mem_addr | output | 17 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Access complete |
| busy | output | 1 | Request in progress |
| eot_irq | output | 1 | End-of-transfer pulse |

## Verification
The bench targets the word write at 0xFFFF. A design that wraps the address would overwrite location 0x0000 instead of 0x10000, and would report 0x0001 as the next write address. Sums that overflow a byte are checked for truncation, and a byte write is checked to leave its neighbour intact, which catches a carry or a stray upper byte leaking into memory. A burst of extra requests during one busy span must yield exactly one extra element. A descriptor write during that span must not redirect the transfer, so a missing lock shows up as data at the wrong address. The linked reload is followed by a request at a count of zero, which a design that failed to stop would turn into a spurious write.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;

    localparam int AW  = 16;       // visible address width
    localparam int XAW = AW + 1;   // kept carry bit for word access at top
    localparam int DW  = 16;       // data width
    localparam int CW  = 16;       // element counter width
    localparam int LW  = 3;        // request priority width
    localparam int BW  = 8;        // byte width

    typedef enum logic [1:0] {
        K_COPY     = 2'b00,
        K_IMM      = 2'b01,
        K_CALC_MEM = 2'b10,
        K_CALC_IMM = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_SRC,
        S_RD_OPD,
        S_WR_DST
    } state_e;

    typedef struct packed {
        kind_e           kind;
        logic            word;
        logic            src_inc;
        logic            dst_inc;
        logic            burst;
        logic            link;
        logic [CW-1:0]   count;
        logic [XAW-1:0]  src;
        logic [XAW-1:0]  dst;
        logic [DW-1:0]   imm;
    } desc_t;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic word);
        logic [DW-1:0] m;
        m = word ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
        return v & m;
    endfunction

    function automatic logic [XAW-1:0] advance(input logic [XAW-1:0] a,
                                               input logic inc, input logic word);
        logic [XAW-1:0] step;
        step = word ? XAW'(2) : XAW'(1);
        return inc ? a + step : a;
    endfunction

    function automatic state_e entry_state(input kind_e k);
        case (k)
            K_COPY:     return S_RD_SRC;
            K_IMM:      return S_WR_DST;
            K_CALC_MEM: return S_RD_SRC;
            default:    return S_RD_OPD;
        endcase
    endfunction

endpackage

// File: rtl/irqdma_gate.sv
module irqdma_gate
    import irqdma_pkg::*;
#(
    parameter int LEVEL_W = LW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_req,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic               route_en,
    input  logic               fast_sel,
    input  logic               idle,
    output logic               start,
    output logic               pend
);
    localparam logic [LEVEL_W-1:0] TOP_LEVEL = {LEVEL_W{1'b1}};

    logic hit;
    assign hit = irq_req && (irq_level == TOP_LEVEL) && route_en && !fast_sel;

    // one-deep hold: requests seen while working collapse into one
    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (idle) pend <= 1'b0;
        else if (hit)  pend <= 1'b1;
    end

    assign start = idle && (hit || pend);
endmodule

// File: rtl/irqdma_desc.sv
module irqdma_desc
    import irqdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_link_sel,
    input  desc_t wr_val,
    input  logic  busy,
    input  logic  step,
    output desc_t act,
    output logic  last
);
    desc_t link_q;

    assign last = (act.count == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= '0;
            link_q <= '0;
        end else begin
            if (wr_en && wr_link_sel)
                link_q <= wr_val;

            if (step) begin
                if (last && act.link) begin
                    act <= link_q;
                end else begin
                    act.count <= act.count - CW'(1);
                    act.src   <= advance(act.src, act.src_inc, act.word);
                    act.dst   <= advance(act.dst, act.dst_inc, act.word);
                end
            end else if (wr_en && !wr_link_sel && !busy) begin
                act <= wr_val;
            end
        end
    end
endmodule

// File: rtl/irqdma_seq.sv
module irqdma_seq
    import irqdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  desc_t          act,
    input  logic           last,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic           idle,
    output logic           step,
    output logic           eot,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_word,
    output logic [XAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    state_e        state;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [DW-1:0] result;
    logic          go;

    assign go = start && (act.count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            opa   <= '0;
            opb   <= '0;
            eot   <= 1'b0;
        end else begin
            eot <= 1'b0;
            case (state)
                S_IDLE: if (go) state <= entry_state(act.kind);
                S_RD_SRC: if (mem_ready) begin
                    opa   <= fit(mem_rdata, act.word);
                    state <= (act.kind == K_CALC_MEM) ? S_RD_OPD : S_WR_DST;
                end
                S_RD_OPD: if (mem_ready) begin
                    opb   <= fit(mem_rdata, act.word);
                    state <= S_WR_DST;
                end
                default: if (mem_ready) begin
                    if (last) begin
                        eot   <= 1'b1;
                        state <= S_IDLE;
                    end else if (act.burst) begin
                        state <= entry_state(act.kind);
                    end else begin
                        state <= S_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (act.kind)
            K_COPY:     result = opa;
            K_IMM:      result = act.imm;
            K_CALC_MEM: result = opa + opb;
            default:    result = act.imm + opb;
        endcase
    end

    assign idle      = (state == S_IDLE);
    assign step      = (state == S_WR_DST) && mem_ready;
    assign mem_req   = !idle;
    assign mem_we    = (state == S_WR_DST);
    assign mem_word  = act.word;
    assign mem_addr  = (state == S_RD_SRC) ? act.src : act.dst;
    assign mem_wdata = fit(result, act.word);
endmodule

// File: rtl/irqdma_top.sv
module irqdma_top
    import irqdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           irq_req,
    input  logic [LW-1:0]  irq_level,
    input  logic           dma_route_en,
    input  logic           fast_irq_sel,
    input  logic           desc_we,
    input  logic           desc_link_sel,
    input  logic [1:0]     desc_kind,
    input  logic           desc_word,
    input  logic           desc_src_inc,
    input  logic           desc_dst_inc,
    input  logic           desc_burst,
    input  logic           desc_link,
    input  logic [CW-1:0]  desc_count,
    input  logic [AW-1:0]  desc_src,
    input  logic [AW-1:0]  desc_dst,
    input  logic [DW-1:0]  desc_imm,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_word,
    output logic [XAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           busy,
    output logic           eot_irq
);
    desc_t wr_val;
    desc_t act;
    logic  idle, start, pend, step, last;

    always_comb begin
        wr_val.kind    = kind_e'(desc_kind);
        wr_val.word    = desc_word;
        wr_val.src_inc = desc_src_inc;
        wr_val.dst_inc = desc_dst_inc;
        wr_val.burst   = desc_burst;
        wr_val.link    = desc_link;
        wr_val.count   = desc_count;
        wr_val.src     = {1'b0, desc_src};
        wr_val.dst     = {1'b0, desc_dst};
        wr_val.imm     = desc_imm;
    end

    irqdma_gate #(.LEVEL_W(LW)) u_gate (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_level(irq_level),
        .route_en(dma_route_en), .fast_sel(fast_irq_sel), .idle(idle),
        .start(start), .pend(pend)
    );

    irqdma_desc u_desc (
        .clk(clk), .rst(rst), .wr_en(desc_we), .wr_link_sel(desc_link_sel),
        .wr_val(wr_val), .busy(busy), .step(step), .act(act), .last(last)
    );

    irqdma_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .act(act), .last(last),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .idle(idle),
        .step(step), .eot(eot_irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign busy = !idle;
endmodule

// File: rtl/irqdma_checker.sv
module irqdma_checker
    import irqdma_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           irq_req,
    input logic [LW-1:0]  irq_level,
    input logic           dma_route_en,
    input logic           fast_irq_sel,
    input logic           pend,
    input logic           busy,
    input logic           eot_irq,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_word,
    input logic           mem_ready,
    input logic [XAW-1:0] mem_addr,
    input logic [DW-1:0]  mem_wdata
);
    a_r1_blocked_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pend && !(irq_req && irq_level == {LW{1'b1}} && dma_route_en && !fast_irq_sel))
        |=> !busy);

    a_r14_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r9_eot_single_cycle: assert property (@(posedge clk) disable iff (rst)
        eot_irq |=> !eot_irq);

    a_r9_eot_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_irq) |-> $past(mem_req && mem_we && mem_ready));

    a_r12_access_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_word) |-> (mem_wdata[DW-1:BW] == '0));
endmodule

bind irqdma_top irqdma_checker u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_level(irq_level),
    .dma_route_en(dma_route_en), .fast_irq_sel(fast_irq_sel), .pend(pend),
    .busy(busy), .eot_irq(eot_irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_word(mem_word), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_irqdma_top.sv
`timescale 1ns/1ps
module sim_irqdma_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_level = 3'd0;
    logic        dma_route_en = 1'b1;
    logic        fast_irq_sel = 1'b0;
    logic        desc_we = 1'b0, desc_link_sel = 1'b0;
    logic [1:0]  desc_kind = 2'd0;
    logic        desc_word = 1'b0, desc_src_inc = 1'b0, desc_dst_inc = 1'b0;
    logic        desc_burst = 1'b0, desc_link = 1'b0;
    logic [15:0] desc_count = '0, desc_src = '0, desc_dst = '0, desc_imm = '0;
    logic        mem_req, mem_we, mem_word;
    logic [16:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, eot_irq;

    int n_chk = 0, n_fail = 0;
    int eot_cnt = 0, wr_cnt = 0, last_wr = 0;
    logic [7:0] mem [int];

    always #2 clk = ~clk;

    irqdma_top u0 (.*);

    function automatic logic [7:0] rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    // memory model: one wait cycle, then ready
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
        end else begin
            if (mem_req && mem_we && mem_ready) begin
                mem[int'(mem_addr)] = mem_wdata[7:0];
                if (mem_word) mem[int'(mem_addr) + 1] = mem_wdata[15:8];
                wr_cnt  = wr_cnt + 1;
                last_wr = int'(mem_addr);
            end
            if (eot_irq) eot_cnt = eot_cnt + 1;
            mem_ready <= (mem_req && !mem_ready);
        end
    end

    always @(negedge clk) mem_rdata = {rd(int'(mem_addr) + 1), rd(int'(mem_addr))};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic sel, input logic [1:0] kind, input logic word,
                        input logic sinc, input logic dinc, input logic burst,
                        input logic link, input int cnt, input int src,
                        input int dst, input int imm);
        @(negedge clk);
        desc_we = 1'b1; desc_link_sel = sel; desc_kind = kind; desc_word = word;
        desc_src_inc = sinc; desc_dst_inc = dinc; desc_burst = burst;
        desc_link = link; desc_count = 16'(cnt); desc_src = 16'(src);
        desc_dst = 16'(dst); desc_imm = 16'(imm);
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic fire(input logic [2:0] lvl);
        @(negedge clk);
        irq_req = 1'b1; irq_level = lvl;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        for (int i = 0; i < 400 && quiet < 4; i++) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic t_reset();
        chk("R12 busy after reset", busy, 0);
        chk("R14 no access after reset", mem_req, 0);
        chk("R9 no eot after reset", eot_irq, 0);
    endtask

    task automatic t_gating();
        int w0;
        load(0, 2'b01, 0, 0, 0, 0, 0, 1, 0, 16'hA00, 16'h66);
        w0 = wr_cnt;
        fire(3'd6); settle();
        dma_route_en = 1'b0; fire(3'd7); settle(); dma_route_en = 1'b1;
        fast_irq_sel = 1'b1; fire(3'd7); settle(); fast_irq_sel = 1'b0;
        chk("R1 blocked requests write nothing", wr_cnt - w0, 0);
        chk("R1 memory untouched", rd(16'hA00), 0);
        fire(3'd7); settle();
        chk("R1 qualified request runs", rd(16'hA00), 8'h66);
    endtask

    task automatic t_single_copy();
        int e0;
        mem[16'h100] = 8'h11; mem[16'h101] = 8'h22; mem[16'h102] = 8'h33;
        load(0, 2'b00, 0, 1, 1, 0, 0, 3, 16'h100, 16'h200, 0);
        e0 = eot_cnt;
        fire(3'd7);
        chk("R12 busy after acceptance", busy, 1);
        settle();
        chk("R2 first element copied", rd(16'h200), 8'h11);
        chk("R8 single mode moves one", rd(16'h201), 0);
        fire(3'd7); settle(); fire(3'd7); settle();
        chk("R6 byte step of one", rd(16'h201), 8'h22);
        chk("R2 last element copied", rd(16'h202), 8'h33);
        chk("R9 one eot at zero", eot_cnt - e0, 1);
    endtask

    task automatic t_burst_imm();
        int e0, w0;
        e0 = eot_cnt; w0 = wr_cnt;
        load(0, 2'b01, 1, 0, 1, 1, 0, 2, 0, 16'h300, 16'hBEEF);
        fire(3'd7); settle();
        chk("R3 imm low byte", rd(16'h300), 8'hEF);
        chk("R5 word high byte", rd(16'h301), 8'hBE);
        chk("R6 word step of two", rd(16'h302), 8'hEF);
        chk("R8 burst moves all", wr_cnt - w0, 2);
        chk("R9 burst eot", eot_cnt - e0, 1);
    endtask

    task automatic t_calc();
        mem[16'h110] = 8'hF0; mem[16'h400] = 8'h20; mem[16'h401] = 8'h77;
        load(0, 2'b10, 0, 0, 0, 0, 0, 1, 16'h110, 16'h400, 0);
        fire(3'd7); settle();
        chk("R4 byte sum truncated", rd(16'h400), 8'h10);
        chk("R5 byte write spares neighbour", rd(16'h401), 8'h77);
        mem[16'h500] = 8'h01; mem[16'h501] = 8'h01;
        load(0, 2'b11, 1, 0, 0, 0, 0, 1, 0, 16'h500, 16'h1234);
        fire(3'd7); settle();
        chk("R4 imm plus memory low", rd(16'h500), 8'h35);
        chk("R4 imm plus memory high", rd(16'h501), 8'h13);
    endtask

    task automatic t_fixed_dst();
        int w0;
        w0 = wr_cnt;
        load(0, 2'b00, 0, 1, 0, 1, 0, 3, 16'h100, 16'h700, 0);
        fire(3'd7); settle();
        chk("R6 fixed destination keeps last", rd(16'h700), 8'h33);
        chk("R6 fixed destination no advance", rd(16'h701), 0);
        chk("R8 burst count three", wr_cnt - w0, 3);
    endtask

    task automatic t_top_edge();
        mem[0] = 8'hC3;
        load(0, 2'b01, 1, 0, 1, 1, 0, 2, 0, 16'hFFFF, 16'hA55A);
        fire(3'd7); settle();
        chk("R7 byte at 0xFFFF", rd(32'hFFFF), 8'h5A);
        chk("R7 carry byte at 0x10000", rd(32'h10000), 8'hA5);
        chk("R7 no wrap to zero", rd(0), 8'hC3);
        chk("R7 next address 0x10001", last_wr, 32'h10001);
    endtask

    task automatic t_chain();
        int w0, e0;
        load(1, 2'b01, 0, 0, 0, 0, 0, 1, 0, 16'h610, 16'h55);
        load(0, 2'b01, 0, 0, 0, 0, 1, 1, 0, 16'h600, 16'hAA);
        e0 = eot_cnt;
        fire(3'd7); settle();
        chk("R10 first set written", rd(16'h600), 8'hAA);
        chk("R9 eot on linked expiry", eot_cnt - e0, 1);
        fire(3'd7); settle();
        chk("R10 linked set used", rd(16'h610), 8'h55);
        w0 = wr_cnt;
        fire(3'd7); settle();
        chk("R9 zero count moves nothing", wr_cnt - w0, 0);
        chk("R9 zero count stays idle", busy, 0);
    endtask

    task automatic t_pending();
        int w0;
        w0 = wr_cnt;
        load(0, 2'b00, 0, 1, 1, 0, 0, 3, 16'h100, 16'h800, 0);
        fire(3'd7); fire(3'd7); fire(3'd7);
        settle();
        chk("R11 one held request served", rd(16'h801), 8'h22);
        chk("R11 extra requests merged", wr_cnt - w0, 2);
        chk("R11 third element not moved", rd(16'h802), 0);
    endtask

    task automatic t_locked();
        load(0, 2'b00, 0, 1, 1, 0, 0, 2, 16'h100, 16'h900, 0);
        fire(3'd7);
        load(0, 2'b01, 0, 0, 0, 0, 0, 1, 0, 16'h9F0, 16'hEE);
        settle();
        fire(3'd7); settle();
        chk("R13 original transfer continues", rd(16'h901), 8'h22);
        chk("R13 busy write dropped", rd(16'h9F0), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gating();
        t_single_copy();
        t_burst_imm();
        t_calc();
        t_fixed_dst();
        t_top_edge();
        t_chain();
        t_pending();
        t_locked();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule